// File: doc/BRIEF.md
# Break and output-enable guard with write-once lock

This block protects the power outputs of a motor-control timer. It holds a small configuration register and drives the main output enable, which gates every output channel. A break input can remove that enable at once, with no clock edge in the path. After a fault, the enable comes back in one of two ways: software writes it again, or, when automatic re-enable is selected, the next timer update event sets it. In both cases it comes back only when no break is active.

A two-bit protection level can be written once after reset. The first register write sets it, and later writes leave it unchanged. Level 1 or higher freezes the break configuration: break enable, break polarity, automatic re-enable and bidirectional mode. Level 2 or higher also freezes the two off-state selects. The main output enable and the disarm bit stay writable at every level.

In bidirectional mode, an active break pulls the shared break pin low through an open-drain driver. This tells external devices that a fault occurred. The driver stays on until software sets the disarm bit. Hardware clears the disarm bit once no break remains active.

Top module: `brk_guard`

## Requirements
- R1: After reset, `rd_data` reads 0, `main_oe` is 0 and `brk_od_oe` is 0.
- R2: The protection level sits in register bits [9:8]. Only the first write after reset stores it. Every later write leaves it unchanged until the next reset.
- R3: At level 1 or higher, a write leaves bit 0 (break enable), bit 1 (break polarity), bit 2 (automatic re-enable) and bit 7 (bidirectional mode) unchanged.
- R4: At level 2 or higher, a write also leaves bit 4 (idle off-state select) and bit 5 (run off-state select) unchanged. At level 1, these two bits still accept writes.
- R5: A break is active when break enable is 1 and `brk_in` equals the polarity bit. Polarity 1 means a high pin is active; polarity 0 means a low pin is active.
- R6: An active break drives `main_oe` to 0 in the same cycle, before any clock edge. The stored main-enable bit (bit 3) is cleared at the next edge.
- R7: A write sets or clears bit 3 when no break is active. A write of 1 to bit 3 while a break is active has no effect.
- R8: When bit 2 is 1, a cycle with `upd_evt` high and no active break sets bit 3. A break present in that cycle blocks the set.
- R9: New values of break enable, break polarity, disarm (bit 6) and bidirectional mode change behaviour one cycle after the write is visible in `rd_data`.
- R10: In bidirectional mode, an active break sets `brk_od_oe` at the next edge. It stays set after the break goes away, for as long as disarm is not in effect.
- R11: A disarm in effect clears `brk_od_oe` and keeps it from setting. Hardware clears bit 6 at the first edge where no break is active; a write that sets bit 6 wins over that clear in its own edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 10 | Register write value |
| rd_data | output | 10 | Current register contents |
| brk_in | input | 1 | Break pin level |
| brk_od_oe | output | 1 | Open-drain pull-low enable for the break pin |
| upd_evt | input | 1 | Timer update event pulse |
| main_oe | output | 1 | Main output enable for the channels |

## Verification
The bench drives a break in the very cycle a write arrives, and again in the cycle before new settings take effect. A design that applied settings at once, or that gated the enable through a register, would get `main_oe` wrong by one cycle. It writes the main enable and pulses the update event while a break is held. A design that let software or automatic re-enable override the fault would raise `main_oe` during the break. It writes to protected fields after levels 1 and 2 are set, and writes the level a second time. Leaky protection or a rewritable level would show up in `rd_data`. In bidirectional mode it removes the break before disarming, then disarms while the break is still present. A design that released the pin without a disarm, or cleared the disarm early, would show the wrong `brk_od_oe` or bit 6.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int REG_W      = 10;
  localparam int LOCK_W     = 2;
  localparam int B_EN       = 0;
  localparam int B_POL      = 1;
  localparam int B_AUTO     = 2;
  localparam int B_MAIN     = 3;
  localparam int B_IDLE     = 4;
  localparam int B_RUN      = 5;
  localparam int B_DISARM   = 6;
  localparam int B_BIDIR    = 7;
  localparam int LOCK_LSB   = 8;
  localparam int LVL_CORE   = 1;
  localparam int LVL_OFFSEL = 2;
endpackage

// File: rtl/brk_sense.sv
module brk_sense (
  input  logic en_eff,
  input  logic pol_eff,
  input  logic brk_in,
  output logic brk_active
);
  // level match against chosen polarity, no clock in this path
  assign brk_active = en_eff & ~(brk_in ^ pol_eff);
endmodule

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
  import brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             brk_active,
  output logic             en_eff,
  output logic             pol_eff,
  output logic             disarm_eff,
  output logic             bidir_eff,
  output logic             auto_q,
  output logic             idle_q,
  output logic             run_q,
  output logic             disarm_q,
  output logic [LOCK_W-1:0] lock_q
);
  logic en_q, pol_q, bidir_q, lock_done;
  logic lvl_core, lvl_off;

  assign lvl_core = (lock_q >= LOCK_W'(LVL_CORE));
  assign lvl_off  = (lock_q >= LOCK_W'(LVL_OFFSEL));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; pol_q <= 1'b0; auto_q <= 1'b0; bidir_q <= 1'b0;
      idle_q <= 1'b0; run_q <= 1'b0; disarm_q <= 1'b0;
      lock_q <= '0; lock_done <= 1'b0;
    end else begin
      if (wr_en) begin
        if (!lock_done) begin
          lock_q    <= wr_data[LOCK_LSB +: LOCK_W];
          lock_done <= 1'b1;
        end
        if (!lvl_core) begin
          en_q    <= wr_data[B_EN];
          pol_q   <= wr_data[B_POL];
          auto_q  <= wr_data[B_AUTO];
          bidir_q <= wr_data[B_BIDIR];
        end
        if (!lvl_off) begin
          idle_q <= wr_data[B_IDLE];
          run_q  <= wr_data[B_RUN];
        end
        disarm_q <= wr_data[B_DISARM];
      end else if (!brk_active) begin
        disarm_q <= 1'b0;
      end
    end
  end

  // settings that act with one cycle of delay after the write
  always_ff @(posedge clk) begin
    if (rst) begin
      en_eff <= 1'b0; pol_eff <= 1'b0; disarm_eff <= 1'b0; bidir_eff <= 1'b0;
    end else begin
      en_eff <= en_q; pol_eff <= pol_q; disarm_eff <= disarm_q; bidir_eff <= bidir_q;
    end
  end

  p_lock_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lock_done) |=> (lock_q == $past(lock_q)));
  p_core_locked_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lock_q != '0) |=>
      ({en_q, pol_q, auto_q, bidir_q} == $past({en_q, pol_q, auto_q, bidir_q})));
  p_offsel_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lock_q[LOCK_W-1]) |=> ({idle_q, run_q} == $past({idle_q, run_q})));
  p_disarm_clear_r11: assert property (@(posedge clk) disable iff (rst)
    (disarm_q && !brk_active && !wr_en) |=> !disarm_q);
endmodule

// File: rtl/brk_moe_ctrl.sv
module brk_moe_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_main,
  input  logic auto_q,
  input  logic upd_evt,
  input  logic brk_active,
  input  logic bidir_eff,
  input  logic disarm_eff,
  output logic moe_q,
  output logic main_oe,
  output logic od_q
);
  logic moe_set, moe_clr, od_set;

  assign moe_set = (wr_en & wr_main) | (auto_q & upd_evt);
  assign moe_clr = brk_active | (wr_en & ~wr_main);
  assign od_set  = brk_active & bidir_eff & ~disarm_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      moe_q <= 1'b0;
      od_q  <= 1'b0;
    end else begin
      if (moe_clr)      moe_q <= 1'b0;
      else if (moe_set) moe_q <= 1'b1;
      if (od_set)          od_q <= 1'b1;
      else if (disarm_eff) od_q <= 1'b0;
    end
  end

  // immediate gating: break removes the enable without an edge
  assign main_oe = moe_q & ~brk_active;

  p_brk_clears_r6: assert property (@(posedge clk) disable iff (rst)
    brk_active |=> !moe_q);
  p_wr_sets_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_main && !brk_active) |=> moe_q);
  p_auto_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (auto_q && upd_evt && !brk_active && !wr_en) |=> moe_q);
  p_od_set_r10: assert property (@(posedge clk) disable iff (rst)
    (brk_active && bidir_eff && !disarm_eff) |=> od_q);
  p_od_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (od_q && !disarm_eff) |=> od_q);
  p_od_release_r11: assert property (@(posedge clk) disable iff (rst)
    (disarm_eff && !brk_active) |=> !od_q);
endmodule

// File: rtl/brk_guard.sv
module brk_guard
  import brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             brk_in,
  output logic             brk_od_oe,
  input  logic             upd_evt,
  output logic             main_oe
);
  logic en_eff, pol_eff, disarm_eff, bidir_eff;
  logic auto_q, idle_q, run_q, disarm_q, moe_q, brk_active;
  logic [LOCK_W-1:0] lock_q;
  logic en_r, pol_r, bidir_r;

  brk_sense u_sense (
    .en_eff(en_eff), .pol_eff(pol_eff), .brk_in(brk_in), .brk_active(brk_active)
  );

  brk_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .brk_active(brk_active),
    .en_eff(en_eff), .pol_eff(pol_eff), .disarm_eff(disarm_eff), .bidir_eff(bidir_eff),
    .auto_q(auto_q), .idle_q(idle_q), .run_q(run_q), .disarm_q(disarm_q), .lock_q(lock_q)
  );

  brk_moe_ctrl u_moe (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_main(wr_data[B_MAIN]), .auto_q(auto_q),
    .upd_evt(upd_evt), .brk_active(brk_active), .bidir_eff(bidir_eff),
    .disarm_eff(disarm_eff), .moe_q(moe_q), .main_oe(main_oe), .od_q(brk_od_oe)
  );

  // read view of the written fields: the delayed copies lag, so shadow them here
  always_ff @(posedge clk) begin
    if (rst) begin
      en_r <= 1'b0; pol_r <= 1'b0; bidir_r <= 1'b0;
    end else if (wr_en && lock_q == '0) begin
      en_r <= wr_data[B_EN]; pol_r <= wr_data[B_POL]; bidir_r <= wr_data[B_BIDIR];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[B_EN]     = en_r;
    rd_data[B_POL]    = pol_r;
    rd_data[B_AUTO]   = auto_q;
    rd_data[B_MAIN]   = moe_q;
    rd_data[B_IDLE]   = idle_q;
    rd_data[B_RUN]    = run_q;
    rd_data[B_DISARM] = disarm_q;
    rd_data[B_BIDIR]  = bidir_r;
    rd_data[LOCK_LSB +: LOCK_W] = lock_q;
  end

  p_lag_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (en_eff == $past(en_r)) && (pol_eff == $past(pol_r)));
endmodule

// File: tb/tb_brk_guard.sv
module tb_brk_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [9:0] wr_data = '0;
  logic [9:0] rd_data;
  logic       brk_in = 1'b0;
  logic       brk_od_oe;
  logic       upd_evt = 1'b0;
  logic       main_oe;

  brk_guard dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .brk_in(brk_in), .brk_od_oe(brk_od_oe), .upd_evt(upd_evt), .main_oe(main_oe)
  );

  always #4 clk = ~clk;

  typedef struct {
    int         cyc;
    int         sig;
    logic [9:0] val;
    string      req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare due expectations late in the low phase
  always @(negedge clk) begin
    #2;
    while (q.size() > 0 && q[0].cyc == cyc) begin
      exp_t it;
      logic [9:0] act;
      it = q.pop_front();
      case (it.sig)
        0: act = rd_data;
        1: act = {9'd0, main_oe};
        default: act = {9'd0, brk_od_oe};
      endcase
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s sig%0d cyc%0d actual %h expected %h", it.req, it.sig, cyc, act, it.val);
      end
    end
  end

  task automatic push(input int dc, input int sig, input logic [9:0] val, input string req);
    exp_t it;
    it.cyc = cyc + dc; it.sig = sig; it.val = val; it.req = req;
    q.push_back(it);
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; upd_evt = 1'b0; brk_in = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      if (q.size() != 0) begin
        errors++;
        $display("FAIL pending expectations actual %0d expected 0", q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    finish_run();
  end

  initial begin
    step();
    do_reset();
    push(0, 0, 10'h000, "R1"); push(0, 1, 0, "R1"); push(0, 2, 0, "R1");
    step();

    // first write stores level 0 and sets main enable
    wr(10'h008);
    push(0, 0, 10'h008, "R7"); push(0, 1, 1, "R7");
    step();
    // second write tries level 1: ignored
    wr(10'h13B);
    push(0, 0, 10'h03B, "R2");
    brk_in = 1'b1;                       // high active, but enable not yet in effect
    push(0, 1, 1, "R9");
    push(1, 1, 0, "R6");
    step(2);
    push(0, 0, 10'h033, "R6");
    wr(10'h03B);                         // set main during break: no effect
    push(0, 0, 10'h033, "R7"); push(0, 1, 0, "R7");
    step();
    brk_in = 1'b0;
    wr(10'h037);                         // automatic re-enable on
    push(0, 0, 10'h037, "R8");
    upd_evt = 1'b1; step(); upd_evt = 1'b0;
    push(0, 0, 10'h03F, "R8"); push(0, 1, 1, "R8");
    step();
    brk_in = 1'b1;
    push(0, 1, 0, "R6");
    step(2);
    upd_evt = 1'b1; step(); upd_evt = 1'b0;
    push(0, 1, 0, "R8");
    step();
    brk_in = 1'b0;
    push(0, 0, 10'h037, "R8");
    step();

    // polarity low: low pin becomes active one cycle after the write
    wr(10'h03D);
    push(0, 0, 10'h03D, "R9"); push(0, 1, 1, "R9");
    push(1, 1, 0, "R5");
    step(2);
    brk_in = 1'b1;                       // high is now inactive
    wr(10'h03D);
    push(0, 0, 10'h03D, "R5"); push(0, 1, 1, "R5");
    step();

    // level 1
    do_reset();
    wr(10'h10B);
    push(0, 0, 10'h10B, "R2"); push(0, 1, 1, "R2");
    step();
    brk_in = 1'b0;
    wr(10'h3BC);
    push(0, 0, 10'h13B, "R3");
    step();

    // level 2 with bidirectional break
    do_reset();
    wr(10'h29B);
    push(0, 0, 10'h29B, "R2");
    step();
    wr(10'h028);
    push(0, 0, 10'h29B, "R4");
    step();
    brk_in = 1'b1;
    push(0, 1, 0, "R6"); push(0, 2, 0, "R10"); push(1, 2, 1, "R10");
    step();
    brk_in = 1'b0;
    step(4);
    push(0, 2, 1, "R10");
    wr(10'h040);
    push(0, 0, 10'h2D3, "R11"); push(1, 0, 10'h293, "R11"); push(2, 2, 0, "R11");
    step(3);

    // disarm while break still present
    brk_in = 1'b1;
    push(1, 2, 1, "R10");
    step();
    wr(10'h040);
    push(0, 0, 10'h2D3, "R11");
    push(2, 2, 0, "R11"); push(2, 0, 10'h2D3, "R11");
    step(2);
    brk_in = 1'b0;
    push(1, 0, 10'h293, "R11"); push(2, 2, 0, "R11");
    step(4);
    finish_run();
  end
endmodule